// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Enable Registers

This block is the interrupt slice of a real-time clock's register file. It keeps three event flags (periodic tick, alarm match, update ended), a summary bit that reports an enabled pending event, the enable register that masks those flags, and the level interrupt line that goes to the system interrupt controller. The periodic and update/alarm units pulse the event inputs for one cycle per event.

A host reaches the registers through a byte-wide, two-address port. A write to the even address picks a register by its 7-bit index. An access to the odd address then reads or writes that register. A read of the flag register returns the flags and clears all of them, which is how the interrupt is acknowledged. A write to the enable register re-evaluates the line at once against the flags already pending.

The interrupt line comes from a two-state machine. `LINE_LOW` means no enabled event is unacknowledged and the line is low. `LINE_HIGH` means the line is high. The transition *raise* takes `LINE_LOW` to `LINE_HIGH` on an enabled fresh event or on an enable write that overlaps pending flags. The transition *ack* takes `LINE_HIGH` to `LINE_LOW` on a flag-register read, an enable write with no overlap, or a device reset. A fresh event in the same cycle as an ack keeps the machine in `LINE_HIGH`.

Top module: `rtc_irq_regs`

## Requirements
- R1: A host write to the even address (host_addr=0) latches wdata[6:0] as the register index, and bit 7 is dropped. Odd-address accesses (host_addr=1) target that index. The indices are 0x0A control A, 0x0B enable/control B, 0x0C flags and 0x0D status.
- R2: After rst_n goes low, the registers read A=0x26, B=0x02, flags=0x00 and status=0x80, and irq is 0.
- R3: A pulse on evt_periodic, evt_alarm or evt_update sets flag bit 6, 5 or 4 respectively, whether or not the matching enable is set.
- R4: If an event sets a flag that was clear and the enable bit at the same position in B (bit 6, 5 or 4) is 1, flag bit 7 and irq are 1 from the next cycle on.
- R5: A read of the flag register returns its current value. From the next cycle the register is 0x00 and irq is 0.
- R6: A write to B whose bits 6..4 overlap a pending flag sets flag bit 7 and irq at once (next cycle). A write to B with no overlap clears bit 7 and irq.
- R7: Host writes to the flag and status registers are ignored, and bit 7 of A cannot be changed by the host.
- R8: A one-cycle dev_reset clears bits 6, 5 and 3 of B, keeps the other bits of B and all of A, clears all flags and lowers irq.
- R9: An event that arrives in the same cycle as a flag-register read is kept pending after the read's clear, and it raises irq if enabled.
- R10: A read of the even address returns 0xFF. A read of any index other than 0x0A..0x0D returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| dev_reset | input | 1 | Synchronous device reset pulse |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_en is high |
| evt_periodic | input | 1 | Periodic tick event pulse |
| evt_alarm | input | 1 | Alarm match event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench sweeps all eight enable masks against all eight event combinations. A design that set flags only when enabled, or raised the line for masked events, fails there. It also sweeps every pending-flag pattern against every enable write. A design that ignored already pending flags, or left the line high after a non-overlapping write, fails that sweep. The bench drives an event into the same cycle as the acknowledging read, so a design that clears after merging events loses that event. It also covers the device reset's partial clear of B, the read-only registers and bits, and the dropped bit 7 of the index.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 7;
    localparam int NUM_SRC = 3;  // periodic, alarm, update

    localparam logic [IDX_W-1:0] IDX_CTRL_A = 7'h0A;
    localparam logic [IDX_W-1:0] IDX_CTRL_B = 7'h0B;
    localparam logic [IDX_W-1:0] IDX_FLAGS  = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_STAT   = 7'h0D;

    localparam logic [DATA_W-1:0] PWRUP_A    = 8'h26;
    localparam logic [DATA_W-1:0] PWRUP_B    = 8'h02;
    localparam logic [DATA_W-1:0] PWRUP_STAT = 8'h80;
    // enables dropped by device reset: periodic, alarm, square wave
    localparam logic [DATA_W-1:0] DEVRST_B_CLR = 8'h68;

    localparam int SRC_LSB = 4;          // flag/enable bits 6..4
    localparam int SUM_BIT = 7;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;
endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_we,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [IDX_W-1:0]  idx_q,
    output logic              wr_a,
    output logic              wr_b,
    output logic              rd_flags
);
    logic data_wr, data_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (host_en && host_we && !host_addr)
            idx_q <= host_wdata[IDX_W-1:0];
    end

    always_comb begin
        data_wr  = host_en && host_we && host_addr;
        data_rd  = host_en && !host_we && host_addr;
        wr_a     = data_wr && (idx_q == IDX_CTRL_A);
        wr_b     = data_wr && (idx_q == IDX_CTRL_B);
        rd_flags = data_rd && (idx_q == IDX_FLAGS);
    end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_reset,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_a_q,
    output logic [DATA_W-1:0] ctrl_b_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a_q <= PWRUP_A;
            ctrl_b_q <= PWRUP_B;
        end else begin
            if (wr_a)
                ctrl_a_q <= {ctrl_a_q[DATA_W-1], wdata[DATA_W-2:0]};
            if (dev_reset)
                ctrl_b_q <= ctrl_b_q & ~DEVRST_B_CLR;
            else if (wr_b)
                ctrl_b_q <= wdata;
        end
    end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
    import rtc_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dev_reset,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               rd_flags,
    input  logic               wr_b,
    input  logic [NUM_SRC-1:0] en_wr,
    input  logic [NUM_SRC-1:0] en_cur,
    output logic [NUM_SRC-1:0] flag_q,
    output logic               irq
);
    line_state_e state_q, state_d;
    logic [NUM_SRC-1:0] base, flag_d, fresh, en_eff;
    logic raise, overlap;

    always_comb begin
        base    = rd_flags ? '0 : flag_q;
        flag_d  = base | evt;
        fresh   = evt & ~base;
        en_eff  = wr_b ? en_wr : en_cur;
        raise   = |(fresh & en_eff);
        overlap = |(en_wr & flag_q);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW:
                if (raise || (wr_b && overlap))
                    state_d = LINE_HIGH;
            LINE_HIGH:
                if (!raise && (rd_flags || (wr_b && !overlap)))
                    state_d = LINE_LOW;
            default: state_d = LINE_LOW;
        endcase
        if (dev_reset)
            state_d = LINE_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_LOW;
            flag_q  <= '0;
        end else begin
            state_q <= state_d;
            flag_q  <= dev_reset ? '0 : flag_d;
        end
    end

    always_comb irq = (state_q == LINE_HIGH);
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_reset,
    input  logic              host_en,
    input  logic              host_we,
    input  logic              host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    output logic              irq
);
    logic [IDX_W-1:0]   idx_q;
    logic               wr_a, wr_b, rd_flags;
    logic [DATA_W-1:0]  ctrl_a_q, ctrl_b_q;
    logic [NUM_SRC-1:0] flag_q;

    rtc_host_port u_port (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .idx_q(idx_q),
        .wr_a(wr_a), .wr_b(wr_b), .rd_flags(rd_flags)
    );

    rtc_ctrl_regs u_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .wr_a(wr_a),
        .wr_b(wr_b), .wdata(host_wdata), .ctrl_a_q(ctrl_a_q), .ctrl_b_q(ctrl_b_q)
    );

    rtc_flag_unit u_flags (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset),
        .evt({evt_periodic, evt_alarm, evt_update}),
        .rd_flags(rd_flags), .wr_b(wr_b),
        .en_wr(host_wdata[SRC_LSB+NUM_SRC-1:SRC_LSB]),
        .en_cur(ctrl_b_q[SRC_LSB+NUM_SRC-1:SRC_LSB]),
        .flag_q(flag_q), .irq(irq)
    );

    always_comb begin
        if (!host_addr)
            host_rdata = '1;
        else begin
            unique case (idx_q)
                IDX_CTRL_A: host_rdata = ctrl_a_q;
                IDX_CTRL_B: host_rdata = ctrl_b_q;
                IDX_FLAGS:  host_rdata = {irq, flag_q, {SRC_LSB{1'b0}}};
                IDX_STAT:   host_rdata = PWRUP_STAT;
                default:    host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_irq_regs_chk.sv
module rtc_irq_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dev_reset,
    input logic       host_en,
    input logic       host_we,
    input logic       host_addr,
    input logic [6:0] idx_q,
    input logic [7:0] ctrl_b_q,
    input logic [2:0] flag_q,
    input logic       evt_periodic,
    input logic       evt_alarm,
    input logic       evt_update,
    input logic       irq
);
    logic any_evt, host_wr, flag_rd;
    always_comb begin
        any_evt = evt_periodic || evt_alarm || evt_update;
        host_wr = host_en && host_we;
        flag_rd = host_en && !host_we && host_addr && (idx_q == 7'h0C);
    end

    // R3
    update_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_update && !dev_reset) |=> flag_q[0]);

    // R4
    periodic_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_periodic && ctrl_b_q[6] && !flag_q[2] && !dev_reset && !host_wr) |=> irq);

    // R4
    line_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != 3'b000));

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !any_evt) |=> (flag_q == 3'b000) && !irq);

    // R8
    dev_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> !irq && (flag_q == 3'b000) && !ctrl_b_q[6] && !ctrl_b_q[5] && !ctrl_b_q[3]);
endmodule

bind rtc_irq_regs rtc_irq_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .host_en(host_en),
    .host_we(host_we), .host_addr(host_addr), .idx_q(idx_q),
    .ctrl_b_q(ctrl_b_q), .flag_q(flag_q), .evt_periodic(evt_periodic),
    .evt_alarm(evt_alarm), .evt_update(evt_update), .irq(irq)
);

// File: tb/test_rtc_irq_regs.sv
module test_rtc_irq_regs;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, dev_reset = 0;
    logic host_en = 0, host_we = 0, host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic evt_periodic = 0, evt_alarm = 0, evt_update = 0, irq;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_regs i_rtc_irq_regs (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .host_en(host_en),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .evt_periodic(evt_periodic),
        .evt_alarm(evt_alarm), .evt_update(evt_update), .irq(irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic host_wr(logic a, logic [7:0] d);
        @(negedge clk);
        host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 0; host_we = 0;
    endtask

    // read at odd address of index idx; optional simultaneous events
    task automatic reg_rd(logic [6:0] idx, logic [2:0] ev, output logic [7:0] v);
        host_wr(1'b0, {1'b0, idx});
        host_en = 1; host_we = 0; host_addr = 1;
        {evt_periodic, evt_alarm, evt_update} = ev;
        #1 v = host_rdata;
        @(negedge clk);
        host_en = 0;
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    task automatic pulse(logic [2:0] ev);
        {evt_periodic, evt_alarm, evt_update} = ev;
        @(negedge clk);
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    task automatic set_b(logic [7:0] d);
        host_wr(1'b0, 8'h0B);
        host_wr(1'b1, d);
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 power-up values
        check("R2 irq", {7'b0, irq}, 8'h00);
        reg_rd(7'h0A, 0, v); check("R2 A", v, 8'h26);
        reg_rd(7'h0B, 0, v); check("R2 B", v, 8'h02);
        reg_rd(7'h0C, 0, v); check("R2 flags", v, 8'h00);
        reg_rd(7'h0D, 0, v); check("R2 status", v, 8'h80);

        // R1 bit 7 of index dropped
        host_wr(1'b0, 8'h8A);
        host_en = 1; host_we = 0; host_addr = 1; #1;
        check("R1 index 0x8A->0x0A", host_rdata, 8'h26);
        @(negedge clk); host_en = 0;

        // R10 even-port read and unused index
        host_en = 1; host_we = 0; host_addr = 0; #1;
        check("R10 even read", host_rdata, 8'hFF);
        @(negedge clk); host_en = 0;
        reg_rd(7'h20, 0, v); check("R10 unused index", v, 8'h00);

        // R3 R4 R5 sweep: enables x events
        for (int e = 0; e < 8; e++) begin
            for (int f = 0; f < 8; f++) begin
                logic [7:0] exp;
                set_b({1'b0, e[2:0], 4'h2});
                reg_rd(7'h0C, 0, v);
                pulse(f[2:0]);
                exp = {((e & f) != 0) ? 1'b1 : 1'b0, f[2:0], 4'h0};
                check("R4 irq after event", {7'b0, irq}, {7'b0, exp[7]});
                reg_rd(7'h0C, 0, v);
                check("R3 flags value", v, exp);
                check("R5 irq after read", {7'b0, irq}, 8'h00);
                reg_rd(7'h0C, 0, v);
                check("R5 flags cleared", v, 8'h00);
            end
        end

        // R6 sweep: pending flags x enable write
        for (int f = 0; f < 8; f++) begin
            for (int e = 0; e < 8; e++) begin
                logic hit;
                set_b(8'h02);
                reg_rd(7'h0C, 0, v);
                pulse(f[2:0]);
                set_b({1'b0, e[2:0], 4'h2});
                hit = (e & f) != 0;
                check("R6 irq after enable write", {7'b0, irq}, {7'b0, hit});
                reg_rd(7'h0C, 0, v);
                check("R6 summary bit", v, {hit, f[2:0], 4'h0});
            end
        end
        // R6 non-overlapping write lowers a raised line
        set_b(8'h42); reg_rd(7'h0C, 0, v);
        pulse(3'b100);
        check("R6 raised", {7'b0, irq}, 8'h01);
        set_b(8'h22);
        check("R6 lowered by disjoint write", {7'b0, irq}, 8'h00);
        reg_rd(7'h0C, 0, v);
        check("R6 flags keep periodic", v, 8'h40);

        // R9 event during the acknowledging read
        set_b(8'h12); reg_rd(7'h0C, 0, v);
        pulse(3'b001);
        reg_rd(7'h0C, 3'b001, v);
        check("R9 read value", v, 8'h90);
        check("R9 irq stays high", {7'b0, irq}, 8'h01);
        reg_rd(7'h0C, 0, v);
        check("R9 event kept", v, 8'h90);

        // R7 read-only registers and bit
        host_wr(1'b0, 8'h0C); host_wr(1'b1, 8'hFF);
        reg_rd(7'h0C, 0, v); check("R7 flags write ignored", v, 8'h00);
        host_wr(1'b0, 8'h0D); host_wr(1'b1, 8'h00);
        reg_rd(7'h0D, 0, v); check("R7 status write ignored", v, 8'h80);
        host_wr(1'b0, 8'h0A); host_wr(1'b1, 8'hFF);
        reg_rd(7'h0A, 0, v); check("R7 A bit7 read-only", v, 8'h7F);

        // R8 device reset
        set_b(8'h7A); reg_rd(7'h0C, 0, v);
        pulse(3'b111);
        check("R8 irq before", {7'b0, irq}, 8'h01);
        @(negedge clk); dev_reset = 1;
        @(negedge clk); dev_reset = 0;
        check("R8 irq low", {7'b0, irq}, 8'h00);
        reg_rd(7'h0B, 0, v); check("R8 B partial clear", v, 8'h12);
        reg_rd(7'h0C, 0, v); check("R8 flags clear", v, 8'h00);
        reg_rd(7'h0A, 0, v); check("R8 A kept", v, 8'h7F);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule